// File: doc/BRIEF.md
# Register-Access Serial Slave (32-bit full-duplex frames)

This block is a serial-peripheral slave that works in clock mode 0. It lets an external host read and write a bank of up to 32 registers, each 25 bits wide. Every transaction is one 32-bit frame, sent most significant bit first. The first six bits the host sends give the direction and the register number. On a write, the host's last 25 bits become the new register value. On a read, the slave returns the register's contents in the low 25 bits of the same frame.

The register storage is not part of the block. It sits behind a simple parallel port: a read strobe with an address, for which the storage returns data combinationally in the same cycle, and a write strobe with an address and data. The serial clock, data-in and select lines are brought into the system clock domain through two-flop synchronizers, and all edge detection happens there. The system clock must therefore run several times faster than the serial clock. A configuration input sets whether the select line is active low or active high.

Top module: `spi_regport`

## Requirements
- R1: A frame is 32 bits, most significant bit first, sampled on rising serial-clock edges with the clock idle low. Bit 31 = 1 requests a write and 0 requests a read. Bits 30:26 are the register number. Bits 24:0 are the value.
- R2: A write is committed only after exactly 32 rising edges followed by the release of select. The commit is a single-cycle `bus_wr` pulse, issued after the release, that carries the frame's address and bits 24:0.
- R3: In a read frame, once the sixth bit is received, one `bus_rd` pulse is issued with the address while select is still active. The value on `bus_rdata` is returned on MISO as bits 24:0 of the same frame.
- R4: MISO carries 0 during bits 31:25 of every frame and during the whole of a write frame. Bit 25 of the incoming frame never reaches `bus_wdata`.
- R5: A frame with fewer or more than 32 rising edges produces no `bus_wr`, and the addressed register keeps its old value.
- R6: When `cs_act_high` = 0, select is active when the pin is low. When `cs_act_high` = 1, it is active when the pin is high. Frames behave the same way under either setting.
- R7: A write frame issues no `bus_rd`, and a read frame issues no `bus_wr`. The two strobes are never high together, and each lasts exactly one cycle.
- R8: MISO is 0 whenever select has been inactive for more than four system clocks.
- R9: After reset, `miso`, `bus_wr` and `bus_rd` are 0.
- R10: Serial-clock edges that arrive while select is inactive produce no strobe, and they do not affect the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_act_high | input | 1 | Select polarity: 1 = active high, 0 = active low |
| spi_cs | input | 1 | Serial select pin (asynchronous) |
| spi_sclk | input | 1 | Serial clock pin (asynchronous) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_rd | output | 1 | Single-cycle read strobe toward register storage |
| bus_wr | output | 1 | Single-cycle write strobe toward register storage |
| bus_addr | output | 5 | Register number for either strobe |
| bus_wdata | output | 25 | Write value, valid with `bus_wr` |
| bus_rdata | input | 25 | Read value, valid combinationally during `bus_rd` |

## Verification
A wrong bit counter or a misaligned header shows up within the same frame. The strobe either fails to appear, appears at release for a frame that was cut short or ran long, or carries the wrong register number. All of these can be seen on `bus_addr` a few system clocks after the select line is released. A transmit register that is loaded or shifted at the wrong time shifts the returned word by one or more bit positions, which corrupts the very read that exposed it. Stale transmit contents would appear on MISO while select is idle, and that pin is compared on every clock.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
   localparam int unsigned FRAME_BITS_DEF = 32;
   localparam int unsigned ADDR_BITS_DEF  = 5;
   localparam int unsigned DATA_BITS_DEF  = 25;
   localparam int unsigned SYNC_DEPTH_DEF = 2;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } rp_op_e;
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("spi_rp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_rp_rx.sv
module spi_rp_rx #(
   parameter int unsigned FRAME_W = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_on,
   input  logic              sclk_rise,
   input  logic              mosi_b,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wdata
);
   import spi_regport_pkg::*;

   localparam int unsigned HDR_W   = ADDR_W + 1;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

   logic [FRAME_W-1:0] rx;
   logic [CNT_W-1:0]   cnt;
   logic               cs_on_q;
   rp_op_e             hdr_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx       <= '0;
         cnt      <= '0;
         cs_on_q  <= 1'b0;
         hdr_op   <= OP_READ;
         hdr_addr <= '0;
         rd_stb   <= 1'b0;
         wr_stb   <= 1'b0;
         wdata    <= '0;
      end else begin
         rd_stb  <= 1'b0;
         wr_stb  <= 1'b0;
         cs_on_q <= cs_on;
         if (!cs_on) begin
            cnt <= '0;
            if (cs_on_q && cnt == CNT_FULL && hdr_op == OP_WRITE) begin
               wr_stb <= 1'b1;
               wdata  <= rx[DATA_W-1:0];
            end
         end else if (sclk_rise) begin
            rx <= {rx[FRAME_W-2:0], mosi_b};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            if (cnt == CNT_HDR) begin
               hdr_op   <= rp_op_e'(rx[HDR_W-2]);
               hdr_addr <= {rx[ADDR_W-2:0], mosi_b};
               rd_stb   <= (rp_op_e'(rx[HDR_W-2]) == OP_READ);
            end
         end
      end
   end
endmodule

// File: rtl/spi_rp_tx.sv
module spi_rp_tx #(
   parameter int unsigned DATA_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_on,
   input  logic              sclk_fall,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              miso
);
   localparam int unsigned TX_W = DATA_W + 2;

   logic [TX_W-1:0] tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tx <= '0;
      else if (!cs_on)    tx <= '0;
      else if (load)      tx <= {2'b00, load_data};
      else if (sclk_fall) tx <= {tx[TX_W-2:0], 1'b0};
   end

   assign miso = tx[TX_W-1];
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
   parameter int unsigned FRAME_W    = spi_regport_pkg::FRAME_BITS_DEF,
   parameter int unsigned ADDR_W     = spi_regport_pkg::ADDR_BITS_DEF,
   parameter int unsigned DATA_W     = spi_regport_pkg::DATA_BITS_DEF,
   parameter int unsigned SYNC_DEPTH = spi_regport_pkg::SYNC_DEPTH_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_high,
   input  logic              spi_cs,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   if (FRAME_W != ADDR_W + DATA_W + 2) begin : g_bad_layout
      $error("spi_regport: FRAME_W must equal op bit + address + pad bit + data");
   end

   logic [2:0] pins_s;
   logic       sclk_q;
   logic       cs_on;
   logic       sclk_rise;
   logic       sclk_fall;

   spi_rp_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_cs, spi_mosi, spi_sclk}),
      .q_out (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= pins_s[0];
   end

   assign cs_on     = (pins_s[2] == cs_act_high);
   assign sclk_rise = pins_s[0] & ~sclk_q;
   assign sclk_fall = ~pins_s[0] & sclk_q;

   spi_rp_rx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_on     (cs_on),
      .sclk_rise (sclk_rise),
      .mosi_b    (pins_s[1]),
      .hdr_addr  (bus_addr),
      .rd_stb    (bus_rd),
      .wr_stb    (bus_wr),
      .wdata     (bus_wdata)
   );

   spi_rp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_on     (cs_on),
      .sclk_fall (sclk_fall),
      .load      (bus_rd),
      .load_data (bus_rdata),
      .miso      (spi_miso)
   );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_on,
   input logic miso,
   input logic bus_wr,
   input logic bus_rd
);
   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   // R7
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_wr);

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd);

   // R8
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_on |=> !miso);

   // R2
   wr_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> !cs_on);

   // R3
   rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> cs_on);
endmodule

bind spi_regport spi_regport_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_on  (cs_on),
   .miso   (spi_miso),
   .bus_wr (bus_wr),
   .bus_rd (bus_rd)
);

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_act_high = 1'b0;
   logic        spi_cs = 1'b1;
   logic        spi_sclk = 1'b0;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic        bus_rd, bus_wr;
   logic [4:0]  bus_addr;
   logic [24:0] bus_wdata;
   logic [24:0] bus_rdata;

   logic [24:0] mem     [32];
   logic [24:0] exp_mem [32];

   int n_chk = 0, n_bad = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [4:0]  wr_addr, rd_addr;
   logic [24:0] wr_data;
   int idle_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spi_regport dut_i (
      .clk(clk), .rst_n(rst_n), .cs_act_high(cs_act_high),
      .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   assign bus_rdata = mem[bus_addr];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // model of the external storage plus strobe capture
   always @(negedge clk) begin
      if (bus_wr) begin
         wr_cnt++; wr_addr = bus_addr; wr_data = bus_wdata;
         mem[bus_addr] = bus_wdata;
      end
      if (bus_rd) begin
         rd_cnt++; rd_addr = bus_addr;
      end
   end

   // R8: per-clock comparison of MISO while select is idle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (spi_cs != cs_act_high) idle_cnt++;
         else idle_cnt = 0;
         if (idle_cnt > 4) chk(spi_miso == 1'b0, "R8", {31'd0, spi_miso}, 32'd0);
      end
   end

   task automatic frame(input logic [31:0] w, input int nbits, output logic [31:0] r);
      r = '0;
      wr_cnt = 0; rd_cnt = 0;
      @(negedge clk);
      spi_cs = cs_act_high;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 32) ? w[31-i] : 1'b1;
         repeat (HALF) @(negedge clk);
         if (i < 32) r[31-i] = spi_miso;
         spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs = ~cs_act_high;
      repeat (12) @(negedge clk);
   endtask

   task automatic do_write(input logic [4:0] a, input logic [24:0] d, input logic b25);
      logic [31:0] r;
      frame({1'b1, a, b25, d}, 32, r);
      chk(wr_cnt == 1, "R2", wr_cnt, 1);
      chk(wr_addr == a, "R1", {27'd0, wr_addr}, {27'd0, a});
      chk(wr_data == d, "R4", {7'd0, wr_data}, {7'd0, d});
      chk(rd_cnt == 0, "R7", rd_cnt, 0);
      chk(r == 32'd0, "R4", r, 32'd0);
      exp_mem[a] = d;
   endtask

   task automatic do_read(input logic [4:0] a, input string req);
      logic [31:0] r;
      frame({1'b0, a, 1'b1, 25'h0AAAAAA}, 32, r);
      chk(rd_cnt == 1 && rd_addr == a, "R3", {27'd0, rd_addr}, {27'd0, a});
      chk(wr_cnt == 0, "R7", wr_cnt, 0);
      chk(r == {7'd0, exp_mem[a]}, req, r, {7'd0, exp_mem[a]});
   endtask

   task automatic idle_toggle();
      wr_cnt = 0; rd_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         spi_mosi = 1'b1;
         repeat (4) @(negedge clk);
         spi_sclk = ~spi_sclk;
      end
      spi_sclk = 1'b0;
      repeat (12) @(negedge clk);
      chk(wr_cnt == 0 && rd_cnt == 0, "R10", wr_cnt + rd_cnt, 0);
   endtask

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 32; i++) begin
         mem[i] = 25'((i * 32'h12345 + 7) & 32'h1FFFFFF);
         exp_mem[i] = mem[i];
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spi_miso == 0 && bus_wr == 0 && bus_rd == 0, "R9",
          {29'd0, spi_miso, bus_wr, bus_rd}, 32'd0);
      repeat (5) @(negedge clk);

      do_write(5'd3, 25'h1ABCDEF, 1'b0);
      do_write(5'd31, 25'h0000001, 1'b1);
      do_write(5'd0, 25'h1FFFFFF, 1'b0);
      do_read(5'd3, "R3");
      do_read(5'd31, "R4");
      do_read(5'd0, "R1");
      do_read(5'd17, "R3");

      // R5: short and long frames
      frame({1'b1, 5'd3, 1'b0, 25'h0123456}, 20, r);
      chk(wr_cnt == 0, "R5", wr_cnt, 0);
      frame({1'b1, 5'd3, 1'b0, 25'h0123456}, 6, r);
      chk(wr_cnt == 0 && rd_cnt == 0, "R5", wr_cnt + rd_cnt, 0);
      frame({1'b1, 5'd3, 1'b0, 25'h0123456}, 33, r);
      chk(wr_cnt == 0, "R5", wr_cnt, 0);
      do_read(5'd3, "R5");

      // R10: clock activity with select idle, then a clean frame
      idle_toggle();
      do_read(5'd31, "R10");

      // R6: active-high select
      cs_act_high = 1'b1; spi_cs = 1'b0;
      idle_cnt = 0;
      repeat (10) @(negedge clk);
      do_write(5'd9, 25'h0555555, 1'b0);
      do_read(5'd9, "R6");
      idle_toggle();
      do_read(5'd0, "R6");

      // back to active-low
      cs_act_high = 1'b0; spi_cs = 1'b1;
      idle_cnt = 0;
      repeat (10) @(negedge clk);
      do_write(5'd22, 25'h1000000, 1'b1);
      do_read(5'd22, "R6");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule